// File: doc/BRIEF.md
# Fault Flag Response Controller

This block sits between the fault detectors of a switching power-supply controller and the enable lines of its power stage. Each incoming fault flag has its own small configuration field. The field chooses whether the flag acts on its first sampled cycle or only after it has stayed high for a debounce interval. It also chooses one of eight responses, from doing nothing up to shutting the supply down for good.

The block drives registered enables for the two synchronous rectifiers, the OR-ing FET, the auxiliary PWM output, the main PWM outputs and the supply as a whole. After a shutdown that permits recovery, it counts a programmable restart delay. It can optionally ask for the stored configuration to be reloaded before it re-enables anything. A latched-off shutdown ignores the restart timer and waits for an external power-on request.

All time intervals are counted in pulses of a single-cycle `tick` input. Every interval is a parameter, so a bench can shrink them.

Top module: `fault_response_ctrl`

## Requirements
- R1: Flag i is configured by `flag_cfg[4i+3:4i]`. Bit 3 is the immediate bit and bits 2:0 are the action. With the immediate bit at 1, the action appears on the enable outputs on the second rising edge after the flag is first sampled high.
- R2: With the immediate bit at 0, a flag qualifies only after it has been sampled high on `limit` consecutive ticks. If the flag drops before that, its count restarts from zero. The outputs follow one edge after the flag qualifies.
- R3: The action codes are: 0 no effect; 1 rectifiers off; 2 OR-ing FET off; 3 supply off with automatic restart; 4 auxiliary output off; 5 main PWM off, auxiliary unaffected; 6 rectifiers and OR-ing FET off; 7 supply off and latched.
- R4: An action that has been applied stays in force after its flag drops, until a restart or a `pwr_on` pulse clears it.
- R5: The disables requested by several qualified flags are OR-combined.
- R6: After an automatic-restart shutdown, the supply restarts RESTART_TICKS[`restart_sel`] ticks later. `restart_sel` codes 0 to 3 select the four entries. All enables, including the rectifiers and OR-ing FET, return on the same edge.
- R7: A latched-off shutdown holds until `pwr_on` is sampled high. It overrides a pending automatic restart.
- R8: With `reload_en` set, the block enters the reload state when the restart delay expires. It holds `reload_req` high and the enables low until `reload_done` is sampled high, then restarts on that edge.
- R9: Flags 0 and 1 are the supply and core overvoltage flags. When `ov_ignore` is 1 they have no effect. When it is 0 they act normally.
- R10: The debounce for flags 0 and 1 is OV_LONG_TICKS when `ov_long_deb` is 1 and OV_SHORT_TICKS when it is 0.
- R11: The debounce for all other flags is OC_DEB_TICKS[`oc_deb_sel`], where codes 0 to 7 select the eight entries.
- R12: `status` reads 0 running, 1 waiting to restart, 2 reloading, 3 latched off. During reset every enable is 0 and `status` is 0. On the first edge after reset, all enables go high.
- R13: Whenever `supply_en` is low, every other enable is low too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle time base pulse |
| flags_in | input | NUM_FLAGS | Fault flags, active high |
| flag_cfg | input | 4*NUM_FLAGS | Per-flag immediate bit and action code |
| ov_ignore | input | 1 | Disregard both overvoltage flags |
| ov_long_deb | input | 1 | Long debounce for overvoltage flags |
| oc_deb_sel | input | 3 | Debounce select for the other flags |
| restart_sel | input | 2 | Restart delay select |
| reload_en | input | 1 | Request a configuration reload before restart |
| reload_done | input | 1 | Reload finished |
| pwr_on | input | 1 | External power-on request; clears latched actions |
| sr_en | output | 2 | Synchronous rectifier enables |
| orfet_en | output | 1 | OR-ing FET enable |
| aux_en | output | 1 | Auxiliary PWM enable |
| pwm_en | output | 1 | Main PWM enable |
| supply_en | output | 1 | Whole-supply enable |
| reload_req | output | 1 | Configuration reload request |
| status | output | 2 | Controller state |

## Verification
An immediate flag changes the enables two edges after it is first sampled high: one edge to latch the flag, one for the output register. A debounced flag changes them one edge after its `limit`-th qualifying tick. An automatic restart brings the enables back 2+N edges after the flag was first sampled, where N is the restart delay. A `reload_done` or `pwr_on` pulse releases the outputs on the very edge that samples it. The bench holds `tick` high so that ticks equal edges, counts exactly those edges, and samples on the falling edge that follows. It also samples one edge early to prove that nothing changes before the due cycle.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
  localparam int ACT_W = 3;
  localparam int CFG_W = ACT_W + 1;

  localparam logic [ACT_W-1:0] ACT_NONE      = 3'd0;
  localparam logic [ACT_W-1:0] ACT_SR_OFF    = 3'd1;
  localparam logic [ACT_W-1:0] ACT_OR_OFF    = 3'd2;
  localparam logic [ACT_W-1:0] ACT_RESTART   = 3'd3;
  localparam logic [ACT_W-1:0] ACT_AUX_OFF   = 3'd4;
  localparam logic [ACT_W-1:0] ACT_PWM_OFF   = 3'd5;
  localparam logic [ACT_W-1:0] ACT_SR_OR_OFF = 3'd6;
  localparam logic [ACT_W-1:0] ACT_LATCH_OFF = 3'd7;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_RELOAD  = 2'd2,
    ST_LATCHED = 2'd3
  } ffr_state_e;

  typedef struct packed {
    logic sr;
    logic orfet;
    logic aux;
    logic pwm;
    logic restart;
    logic latch;
  } ffr_disable_t;
endpackage

// File: rtl/ffr_flag_qualifier.sv
module ffr_flag_qualifier #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             flag,
  input  logic             immediate,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      hit   <= 1'b0;
    end else if (!flag) begin
      cnt_q <= '0;
    end else if (!hit) begin
      if (immediate) begin
        hit <= 1'b1;
      end else if (tick) begin
        if (cnt_q + CNT_W'(1) >= limit) begin
          hit   <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ffr_action_map.sv
module ffr_action_map
  import ffr_pkg::*;
#(
  parameter int NUM_FLAGS = 6
) (
  input  logic [NUM_FLAGS-1:0]       hit,
  input  logic [NUM_FLAGS*ACT_W-1:0] acts,
  output ffr_disable_t               dis
);
  always_comb begin
    dis = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (hit[i]) begin
        case (acts[i*ACT_W +: ACT_W])
          ACT_SR_OFF:    dis.sr = 1'b1;
          ACT_OR_OFF:    dis.orfet = 1'b1;
          ACT_RESTART:   dis.restart = 1'b1;
          ACT_AUX_OFF:   dis.aux = 1'b1;
          ACT_PWM_OFF:   dis.pwm = 1'b1;
          ACT_SR_OR_OFF: begin
            dis.sr    = 1'b1;
            dis.orfet = 1'b1;
          end
          ACT_LATCH_OFF: dis.latch = 1'b1;
          default:       ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ffr_restart_seq.sv
module ffr_restart_seq
  import ffr_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             shut_restart,
  input  logic             shut_latch,
  input  logic             reload_en,
  input  logic             reload_done,
  input  logic             pwr_on,
  input  logic [CNT_W-1:0] delay,
  output ffr_state_e       state_q,
  output ffr_state_e       state_n,
  output logic             clear
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (state_q == ST_WAIT) && tick && (cnt_q + CNT_W'(1) >= delay);

  always_comb begin
    state_n = state_q;
    clear   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (pwr_on)            clear = 1'b1;
        else if (shut_latch)   state_n = ST_LATCHED;
        else if (shut_restart) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (shut_latch && !pwr_on) begin
          state_n = ST_LATCHED;
        end else if (pwr_on || expire) begin
          if (reload_en) begin
            state_n = ST_RELOAD;
          end else begin
            state_n = ST_RUN;
            clear   = 1'b1;
          end
        end
      end
      ST_RELOAD: begin
        if (reload_done) begin
          state_n = ST_RUN;
          clear   = 1'b1;
        end
      end
      ST_LATCHED: begin
        if (pwr_on) begin
          if (reload_en) begin
            state_n = ST_RELOAD;
          end else begin
            state_n = ST_RUN;
            clear   = 1'b1;
          end
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      if (state_q != ST_WAIT) cnt_q <= '0;
      else if (tick)          cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl
  import ffr_pkg::*;
#(
  parameter int          NUM_FLAGS         = 6,
  parameter int          OV_SUPPLY_IDX     = 0,
  parameter int          OV_CORE_IDX       = 1,
  parameter int          CNT_W             = 22,
  parameter int unsigned OV_SHORT_TICKS    = 2,
  parameter int unsigned OV_LONG_TICKS     = 500,
  parameter int unsigned OC_DEB_TICKS [8]  = '{2600, 9800, 130000, 260000,
                                               600000, 1300000, 2000000, 2600000},
  parameter int unsigned RESTART_TICKS [4] = '{500000, 1000000, 2000000, 4000000}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic [NUM_FLAGS-1:0]       flags_in,
  input  logic [NUM_FLAGS*CFG_W-1:0] flag_cfg,
  input  logic                       ov_ignore,
  input  logic                       ov_long_deb,
  input  logic [2:0]                 oc_deb_sel,
  input  logic [1:0]                 restart_sel,
  input  logic                       reload_en,
  input  logic                       reload_done,
  input  logic                       pwr_on,
  output logic [1:0]                 sr_en,
  output logic                       orfet_en,
  output logic                       aux_en,
  output logic                       pwm_en,
  output logic                       supply_en,
  output logic                       reload_req,
  output logic [1:0]                 status
);
  logic [NUM_FLAGS-1:0]       flag_gated;
  logic [NUM_FLAGS-1:0]       hit;
  logic [NUM_FLAGS*ACT_W-1:0] acts;
  logic [CNT_W-1:0]           oc_limit;
  logic [CNT_W-1:0]           restart_limit;
  logic                       clear;
  logic                       run_n;
  ffr_state_e                 state_q;
  ffr_state_e                 state_n;
  ffr_disable_t               dis;

  assign oc_limit      = CNT_W'(OC_DEB_TICKS[oc_deb_sel]);
  assign restart_limit = CNT_W'(RESTART_TICKS[restart_sel]);

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    logic [CNT_W-1:0] lim;
    assign acts[gi*ACT_W +: ACT_W] = flag_cfg[gi*CFG_W +: ACT_W];
    if (gi == OV_SUPPLY_IDX || gi == OV_CORE_IDX) begin : g_ov
      assign flag_gated[gi] = flags_in[gi] & ~ov_ignore;
      assign lim = ov_long_deb ? CNT_W'(OV_LONG_TICKS) : CNT_W'(OV_SHORT_TICKS);
    end else begin : g_other
      assign flag_gated[gi] = flags_in[gi];
      assign lim = oc_limit;
    end
    ffr_flag_qualifier #(.CNT_W(CNT_W)) u_qual (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .flag      (flag_gated[gi]),
      .immediate (flag_cfg[gi*CFG_W + ACT_W]),
      .clear     (clear),
      .limit     (lim),
      .hit       (hit[gi])
    );
  end

  ffr_action_map #(.NUM_FLAGS(NUM_FLAGS)) u_map (
    .hit  (hit),
    .acts (acts),
    .dis  (dis)
  );

  ffr_restart_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .shut_restart (dis.restart),
    .shut_latch   (dis.latch),
    .reload_en    (reload_en),
    .reload_done  (reload_done),
    .pwr_on       (pwr_on),
    .delay        (restart_limit),
    .state_q      (state_q),
    .state_n      (state_n),
    .clear        (clear)
  );

  assign run_n = (state_n == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      supply_en <= 1'b0;
      pwm_en    <= 1'b0;
      aux_en    <= 1'b0;
      orfet_en  <= 1'b0;
      sr_en     <= 2'b00;
    end else begin
      supply_en <= run_n;
      pwm_en    <= run_n & ~(dis.pwm & ~clear);
      aux_en    <= run_n & ~(dis.aux & ~clear);
      orfet_en  <= run_n & ~(dis.orfet & ~clear);
      sr_en     <= {2{run_n & ~(dis.sr & ~clear)}};
    end
  end

  assign status     = state_q;
  assign reload_req = (state_q == ST_RELOAD);
endmodule

// File: rtl/ffr_checker.sv
module ffr_checker (
  input logic       clk,
  input logic       rst,
  input logic       pwr_on,
  input logic       reload_done,
  input logic [1:0] sr_en,
  input logic       orfet_en,
  input logic       aux_en,
  input logic       pwm_en,
  input logic       supply_en,
  input logic       reload_req,
  input logic [1:0] status
);
  assert_supply_gate_R13: assert property (@(posedge clk) disable iff (rst)
    !supply_en |-> (!pwm_en && !aux_en && !orfet_en && sr_en == 2'b00));

  assert_wait_off_R6: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd1) |-> !supply_en);

  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd3 && !pwr_on) |=> (status == 2'd3));

  assert_reload_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd2 && !reload_done) |=> (status == 2'd2));

  assert_reload_off_R8: assert property (@(posedge clk) disable iff (rst)
    reload_req |-> !supply_en);

  assert_sr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd0 && supply_en && sr_en == 2'b00 && !pwr_on) |=> (sr_en == 2'b00));
endmodule

bind fault_response_ctrl ffr_checker u_ffr_checker (.*);

// File: tb/test_fault_response_ctrl.sv
module test_fault_response_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 6;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst, tick, ov_ignore, ov_long_deb, reload_en, reload_done, pwr_on;
  logic [NF-1:0] flags_in;
  logic [NF*4-1:0] flag_cfg;
  logic [2:0]    oc_deb_sel;
  logic [1:0]    restart_sel;
  logic [1:0]    sr_en, status;
  logic          orfet_en, aux_en, pwm_en, supply_en, reload_req;
  int            n_checks = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_response_ctrl #(
    .NUM_FLAGS(NF), .CNT_W(16), .OV_SHORT_TICKS(2), .OV_LONG_TICKS(5),
    .OC_DEB_TICKS('{3, 4, 5, 6, 7, 8, 9, 10}),
    .RESTART_TICKS('{4, 6, 8, 10})
  ) i_fault_response_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .flags_in(flags_in), .flag_cfg(flag_cfg),
    .ov_ignore(ov_ignore), .ov_long_deb(ov_long_deb), .oc_deb_sel(oc_deb_sel),
    .restart_sel(restart_sel), .reload_en(reload_en), .reload_done(reload_done),
    .pwr_on(pwr_on), .sr_en(sr_en), .orfet_en(orfet_en), .aux_en(aux_en),
    .pwm_en(pwm_en), .supply_en(supply_en), .reload_req(reload_req), .status(status)
  );

  // {idx[3], imm[1], act[3], edges[4], out{supply,pwm,aux,orfet,sr1,sr0}[6], status[2], req[4]}
  localparam logic [22:0] VECS [NV] = '{
    {3'd2, 1'b1, 3'd1, 4'd1, 6'b111111, 2'd0, 4'd1},  // R1 not yet due
    {3'd2, 1'b1, 3'd1, 4'd2, 6'b111100, 2'd0, 4'd1},  // R1 due
    {3'd3, 1'b1, 3'd2, 4'd2, 6'b111011, 2'd0, 4'd3},  // R3 OR-ing FET
    {3'd4, 1'b1, 3'd4, 4'd2, 6'b110111, 2'd0, 4'd3},  // R3 aux
    {3'd5, 1'b1, 3'd5, 4'd2, 6'b101111, 2'd0, 4'd3},  // R3 main PWM
    {3'd2, 1'b1, 3'd6, 4'd2, 6'b111000, 2'd0, 4'd3},  // R3 rectifiers + FET
    {3'd2, 1'b1, 3'd0, 4'd5, 6'b111111, 2'd0, 4'd3},  // R3 ignore
    {3'd2, 1'b1, 3'd3, 4'd2, 6'b000000, 2'd1, 4'd3},  // R3 auto restart, R13
    {3'd2, 1'b1, 3'd7, 4'd2, 6'b000000, 2'd3, 4'd3},  // R3 latch off, R13
    {3'd2, 1'b0, 3'd1, 4'd3, 6'b111111, 2'd0, 4'd2},  // R2, R11 code 0 early
    {3'd2, 1'b0, 3'd1, 4'd4, 6'b111100, 2'd0, 4'd2},  // R2, R11 code 0 due
    {3'd0, 1'b0, 3'd1, 4'd2, 6'b111111, 2'd0, 4'd10}, // R10 short early
    {3'd0, 1'b0, 3'd1, 4'd3, 6'b111100, 2'd0, 4'd10}, // R10 short due
    {3'd1, 1'b1, 3'd1, 4'd2, 6'b111100, 2'd0, 4'd9}   // R9 ignore clear
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string what, input logic [5:0] eo, input logic [1:0] es,
                       input logic er);
    logic [8:0] got, exp;
    got = {supply_en, pwm_en, aux_en, orfet_en, sr_en, status, reload_req};
    exp = {eo, es, er};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic set_cfg(input int idx, input logic imm, input logic [2:0] act);
    flag_cfg[idx*4 +: 4] = {imm, act};
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b1; flags_in = '0; flag_cfg = '0;
    ov_ignore = 1'b0; ov_long_deb = 1'b0; oc_deb_sel = 3'd0; restart_sel = 2'd0;
    reload_en = 1'b0; reload_done = 1'b0; pwr_on = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R12 reset state and first edge after reset
    rst = 1'b1; tick = 1'b1; flags_in = '0; flag_cfg = '0;
    ov_ignore = 1'b0; ov_long_deb = 1'b0; oc_deb_sel = 3'd0; restart_sel = 2'd0;
    reload_en = 1'b0; reload_done = 1'b0; pwr_on = 1'b0;
    step(3);
    check("R12 during reset", 6'b000000, 2'd0, 1'b0);
    rst = 1'b0;
    step(1);
    check("R12 first edge", 6'b111111, 2'd0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [22:0] e;
      e = VECS[v];
      do_reset();
      set_cfg(int'(e[22:20]), e[19], e[18:16]);
      flags_in[e[22:20]] = 1'b1;
      step(int'(e[15:12]));
      check($sformatf("R%0d vector %0d", e[3:0], v), e[11:6], e[5:4], 1'b0);
    end

    // R9 overvoltage flags disregarded
    do_reset(); ov_ignore = 1'b1;
    set_cfg(0, 1'b1, 3'd3); set_cfg(1, 1'b1, 3'd7); flags_in[1:0] = 2'b11;
    step(4);
    check("R9 ignore set", 6'b111111, 2'd0, 1'b0);

    // R10 long overvoltage debounce
    do_reset(); ov_long_deb = 1'b1;
    set_cfg(1, 1'b0, 3'd1); flags_in[1] = 1'b1;
    step(5);
    check("R10 long early", 6'b111111, 2'd0, 1'b0);
    step(1);
    check("R10 long due", 6'b111100, 2'd0, 1'b0);

    // R11 debounce code 3 gives 6 ticks
    do_reset(); oc_deb_sel = 3'd3;
    set_cfg(2, 1'b0, 3'd1); flags_in[2] = 1'b1;
    step(6);
    check("R11 code 3 early", 6'b111111, 2'd0, 1'b0);
    step(1);
    check("R11 code 3 due", 6'b111100, 2'd0, 1'b0);

    // R2 count restarts when the flag drops
    do_reset();
    set_cfg(2, 1'b0, 3'd1); flags_in[2] = 1'b1;
    step(2); flags_in[2] = 1'b0;
    step(1); flags_in[2] = 1'b1;
    step(3);
    check("R2 restarted count early", 6'b111111, 2'd0, 1'b0);
    step(1);
    check("R2 restarted count due", 6'b111100, 2'd0, 1'b0);

    // R5 disables combine
    do_reset();
    set_cfg(2, 1'b1, 3'd1); set_cfg(4, 1'b1, 3'd4); flags_in[2] = 1'b1; flags_in[4] = 1'b1;
    step(2);
    check("R5 combined", 6'b110100, 2'd0, 1'b0);

    // R4 action held after the flag drops, then pwr_on clears it
    do_reset();
    set_cfg(2, 1'b1, 3'd1); flags_in[2] = 1'b1;
    step(1); flags_in[2] = 1'b0;
    step(5);
    check("R4 held", 6'b111100, 2'd0, 1'b0);
    pwr_on = 1'b1; step(1); pwr_on = 1'b0;
    check("R4 cleared by pwr_on", 6'b111111, 2'd0, 1'b0);

    // R6 restart after 6 ticks with rectifiers and FET back at once
    do_reset(); restart_sel = 2'd1;
    set_cfg(2, 1'b1, 3'd3); set_cfg(3, 1'b1, 3'd6); flags_in[3:2] = 2'b11;
    step(1); flags_in[3:2] = 2'b00;
    step(6);
    check("R6 still waiting", 6'b000000, 2'd1, 1'b0);
    step(1);
    check("R6 restarted", 6'b111111, 2'd0, 1'b0);

    // R8 reload before restart
    do_reset(); reload_en = 1'b1;
    set_cfg(2, 1'b1, 3'd3); flags_in[2] = 1'b1;
    step(1); flags_in[2] = 1'b0;
    step(5);
    check("R8 reload entered", 6'b000000, 2'd2, 1'b1);
    step(3);
    check("R8 reload held", 6'b000000, 2'd2, 1'b1);
    reload_done = 1'b1; step(1); reload_done = 1'b0;
    check("R8 reload finished", 6'b111111, 2'd0, 1'b0);

    // R7 latched off until pwr_on
    do_reset();
    set_cfg(2, 1'b1, 3'd7); flags_in[2] = 1'b1;
    step(1); flags_in[2] = 1'b0;
    step(20);
    check("R7 latched", 6'b000000, 2'd3, 1'b0);
    pwr_on = 1'b1; step(1); pwr_on = 1'b0;
    check("R7 released", 6'b111111, 2'd0, 1'b0);

    // R7 latch overrides a pending restart
    do_reset();
    set_cfg(2, 1'b1, 3'd3); set_cfg(3, 1'b1, 3'd7); flags_in[2] = 1'b1;
    step(1); flags_in[2] = 1'b0;
    step(2);
    check("R7 waiting first", 6'b000000, 2'd1, 1'b0);
    flags_in[3] = 1'b1; step(1); flags_in[3] = 1'b0;
    step(1);
    check("R7 priority", 6'b000000, 2'd3, 1'b0);
    step(5);
    check("R7 no auto restart", 6'b000000, 2'd3, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule